// File: doc/BRIEF.md
# Paged Write Buffer with In-Page Offset Wrap

This block is the staging buffer between a serial programming front end and a paged nonvolatile array. A command opens with a start address. The upper address bits name the page, and the lower bits give the byte offset where incoming data begins. Each data byte is stored at the current offset, and the offset then steps by one. Only the offset advances: when it passes the end of the page it returns to byte zero of the same page, and the page number never changes during the command.

Every slot in the buffer has its own loaded marker. A load-only command can therefore place scattered bytes over several commands, and those bytes stay in the buffer until a commit. A committing command can bring more bytes, or none at all. When the command closes, the block can first issue a row-erase strobe, and then it sweeps every offset of the page in ascending order. The array sees a write strobe only at loaded offsets. After the sweep, all markers are cleared and the load indicator returns high. Ending the programming session throws away all buffered state.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, `busy`, `reload_err`, `mem_wr_en` and `mem_erase` are 0 and `load_flag` is 1.
- R2: `cmd_start` in idle captures the page as `cmd_addr[ADDR_W-1:OFF_W]` (OFF_W = log2 PAGE_BYTES) and the starting offset as `cmd_addr[OFF_W-1:0]`. Every array access of that command uses the captured page.
- R3: Each accepted data byte goes into the current offset, and the offset then increments. Past offset PAGE_BYTES-1 it wraps to offset 0 of the same page.
- R4: `cmd_kind` bit 0 selects commit and bit 1 selects erase-before-commit. Kinds 2'b00 and 2'b10 only load: they never raise `busy`, and their start clears `load_flag` to 0.
- R5: `cmd_end` on a committing kind raises `busy`. For kind 2'b11 the first busy cycle is a single `mem_erase` at offset 0 of the page. One cycle per offset then follows, in ascending order from 0 to PAGE_BYTES-1, and `mem_wr_en` is high only where a byte is loaded.
- R6: When the sweep finishes, `busy` falls, `load_flag` becomes 1 and every loaded marker clears, so a following zero-byte commit writes nothing.
- R7: A committing command may carry zero bytes. It then writes only previously loaded bytes, or, with an empty buffer and kind 2'b11, issues only the erase.
- R8: Bytes from separate load commands, including non-adjacent offsets and different command pages, persist and are all written by the next commit.
- R9: Storing into an already loaded offset overwrites the byte and sets `reload_err`. The flag stays set until `session_end`.
- R10: `session_end` returns the block to idle, aborts any sweep, clears all markers and `reload_err`, and sets `load_flag` to 1.
- R11: While `busy` is high, `cmd_start`, `cmd_end` and `data_valid` are ignored. A `data_valid` outside an open command is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a command (idle only) |
| cmd_kind | input | 2 | Bit 0 commit, bit 1 erase before commit |
| cmd_addr | input | ADDR_W | Page and start offset |
| data_valid | input | 1 | Data byte present |
| data_byte | input | DATA_W | Data byte |
| cmd_end | input | 1 | Closes the open command |
| session_end | input | 1 | Discards all buffered state |
| busy | output | 1 | Erase or sweep in progress |
| load_flag | output | 1 | 0 after a load, 1 after a commit |
| reload_err | output | 1 | Sticky overwrite indicator |
| mem_wr_en | output | 1 | Array byte write strobe |
| mem_erase | output | 1 | Array row erase strobe |
| mem_addr | output | ADDR_W | Array address for the strobes |
| mem_wr_data | output | DATA_W | Array write data |

## Verification
A corrupted offset register shows up on the next commit: bytes land at shifted array addresses, or a wrapped run is written beyond the page instead of at its start. A stale or lost loaded marker shows up in that same commit, as a missing or extra write strobe. A wrong page register or sweep counter is visible on the very first busy cycle. The indicator flags are compared every cycle, so a wrong flag update is seen one cycle after the edge that caused it.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   typedef enum logic [1:0] {
      PB_IDLE  = 2'd0,
      PB_OPEN  = 2'd1,
      PB_ERASE = 2'd2,
      PB_SWEEP = 2'd3
   } pb_state_e;

   localparam int KIND_COMMIT_BIT = 0;
   localparam int KIND_ERASE_BIT  = 1;
endpackage

// File: rtl/pgbuf_addr.sv
module pgbuf_addr #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              step,
   output logic [ADDR_W-OFF_W-1:0] page,
   output logic [OFF_W-1:0]  offset
);
   logic [ADDR_W-OFF_W-1:0] page_q;
   logic [OFF_W-1:0]        off_q;

   // The offset register is exactly OFF_W bits, so incrementing wraps inside the page
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         off_q  <= '0;
      end else if (capture) begin
         page_q <= addr_in[ADDR_W-1:OFF_W];
         off_q  <= addr_in[OFF_W-1:0];
      end else if (step) begin
         off_q  <= off_q + 1'b1;
      end
   end

   assign page   = page_q;
   assign offset = off_q;
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
   parameter int PAGE_BYTES = 64,
   parameter int DATA_W     = 8,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clear_all,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              wr_hit
);
   logic [DATA_W-1:0] data_w  [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid_w;

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("pgbuf_store: PAGE_BYTES must be a power of two, at least 2");
   end

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      logic [DATA_W-1:0] d_q;
      logic              v_q;
      logic              sel;

      assign sel = wr_en && (wr_off == OFF_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
         end else if (clear_all) begin
            v_q <= 1'b0;
         end else if (sel) begin
            v_q <= 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
         end else if (sel) begin
            d_q <= wr_data;
         end
      end

      assign data_w[i]  = d_q;
      assign valid_w[i] = v_q;
   end

   assign rd_data  = data_w[rd_off];
   assign rd_valid = valid_w[rd_off];
   assign wr_hit   = valid_w[wr_off];
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
   import pgbuf_pkg::*;
#(
   parameter int PAGE_BYTES = 64,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [1:0]       cmd_kind,
   input  logic             cmd_end,
   input  logic             data_valid,
   input  logic             session_end,
   input  logic             slot_hit,
   output pb_state_e        state,
   output logic [OFF_W-1:0] sweep_off,
   output logic             capture,
   output logic             accept,
   output logic             clear_all,
   output logic             load_flag,
   output logic             reload_err
);
   pb_state_e        state_q;
   logic [1:0]       kind_q;
   logic [OFF_W-1:0] sweep_q;
   logic             flag_q;
   logic             err_q;
   logic             sweep_last;

   assign sweep_last = (sweep_q == OFF_W'(PAGE_BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PB_IDLE;
         kind_q  <= 2'b00;
         sweep_q <= '0;
         flag_q  <= 1'b1;
         err_q   <= 1'b0;
      end else if (session_end) begin
         state_q <= PB_IDLE;
         sweep_q <= '0;
         flag_q  <= 1'b1;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            PB_IDLE: begin
               if (cmd_start) begin
                  state_q <= PB_OPEN;
                  kind_q  <= cmd_kind;
                  if (!cmd_kind[KIND_COMMIT_BIT]) flag_q <= 1'b0;
               end
            end
            PB_OPEN: begin
               if (data_valid && slot_hit) err_q <= 1'b1;
               if (cmd_end) begin
                  sweep_q <= '0;
                  if (!kind_q[KIND_COMMIT_BIT]) state_q <= PB_IDLE;
                  else if (kind_q[KIND_ERASE_BIT]) state_q <= PB_ERASE;
                  else state_q <= PB_SWEEP;
               end
            end
            PB_ERASE: state_q <= PB_SWEEP;
            PB_SWEEP: begin
               if (sweep_last) begin
                  state_q <= PB_IDLE;
                  flag_q  <= 1'b1;
               end else begin
                  sweep_q <= sweep_q + 1'b1;
               end
            end
            default: state_q <= PB_IDLE;
         endcase
      end
   end

   assign state      = state_q;
   assign sweep_off  = sweep_q;
   assign capture    = (state_q == PB_IDLE) && cmd_start && !session_end;
   assign accept     = (state_q == PB_OPEN) && data_valid && !session_end;
   assign clear_all  = session_end || ((state_q == PB_SWEEP) && sweep_last);
   assign load_flag  = flag_q;
   assign reload_err = err_q;
endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top
   import pgbuf_pkg::*;
#(
   parameter int PAGE_BYTES = 64,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int PAGE_W    = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [1:0]        cmd_kind,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              data_valid,
   input  logic [DATA_W-1:0] data_byte,
   input  logic              cmd_end,
   input  logic              session_end,
   output logic              busy,
   output logic              load_flag,
   output logic              reload_err,
   output logic              mem_wr_en,
   output logic              mem_erase,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wr_data
);
   if (PAGE_W < 1) begin : g_bad_addr
      $error("pgbuf_top: ADDR_W must be wider than the offset field");
   end

   pb_state_e         state;
   logic [OFF_W-1:0]  sweep_off;
   logic [OFF_W-1:0]  load_off;
   logic [PAGE_W-1:0] page;
   logic              capture, accept, clear_all, slot_hit;
   logic [DATA_W-1:0] rd_data;
   logic              rd_valid;

   pgbuf_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .capture(capture), .addr_in(cmd_addr),
      .step(accept), .page(page), .offset(load_off)
   );

   pgbuf_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_off(load_off),
      .wr_data(data_byte), .clear_all(clear_all), .rd_off(sweep_off),
      .rd_data(rd_data), .rd_valid(rd_valid), .wr_hit(slot_hit)
   );

   pgbuf_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
      .cmd_end(cmd_end), .data_valid(data_valid), .session_end(session_end),
      .slot_hit(slot_hit), .state(state), .sweep_off(sweep_off),
      .capture(capture), .accept(accept), .clear_all(clear_all),
      .load_flag(load_flag), .reload_err(reload_err)
   );

   assign busy        = (state == PB_ERASE) || (state == PB_SWEEP);
   assign mem_erase   = (state == PB_ERASE);
   assign mem_wr_en   = (state == PB_SWEEP) && rd_valid;
   assign mem_wr_data = rd_data;
   assign mem_addr    = (state == PB_ERASE) ? {page, {OFF_W{1'b0}}} : {page, sweep_off};
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
   parameter int PAGE_BYTES = 64,
   parameter int ADDR_W     = 16,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int CNT_W     = $clog2(PAGE_BYTES + 4)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              session_end,
   input logic              busy,
   input logic              load_flag,
   input logic              reload_err,
   input logic              mem_wr_en,
   input logic              mem_erase,
   input logic [ADDR_W-1:0] mem_addr
);
   logic [CNT_W-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else busy_run <= '0;
   end

   AST_WR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> busy); // R5
   AST_ERASE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_en && mem_erase)); // R5
   AST_ERASE_AT_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
      mem_erase |-> (mem_addr[OFF_W-1:0] == '0)); // R5
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))); // R2
   AST_OFF_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(mem_erase))
      |-> (mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1)); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reload_err) && !$past(session_end)) |-> reload_err); // R9
   AST_FLAG_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> load_flag); // R6
   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= CNT_W'(PAGE_BYTES + 1)); // R5
endmodule

bind pgbuf_top pgbuf_chk #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .session_end(session_end), .busy(busy),
   .load_flag(load_flag), .reload_err(reload_err), .mem_wr_en(mem_wr_en),
   .mem_erase(mem_erase), .mem_addr(mem_addr)
);

// File: tb/pgbuf_top_bench.sv
module pgbuf_top_bench;
   localparam int P = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_start = 1'b0;
   logic [1:0] cmd_kind = 2'b00;
   logic [15:0] cmd_addr = '0;
   logic data_valid = 1'b0;
   logic [7:0] data_byte = '0;
   logic cmd_end = 1'b0;
   logic session_end = 1'b0;
   logic busy, load_flag, reload_err, mem_wr_en, mem_erase;
   logic [15:0] mem_addr;
   logic [7:0] mem_wr_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pgbuf_top u_pgbuf_top (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
      .cmd_addr(cmd_addr), .data_valid(data_valid), .data_byte(data_byte),
      .cmd_end(cmd_end), .session_end(session_end), .busy(busy),
      .load_flag(load_flag), .reload_err(reload_err), .mem_wr_en(mem_wr_en),
      .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_wr_data(mem_wr_data)
   );

   // Behavioural reference: mode 0 idle, 1 open, 2 erase, 3 sweep
   int m_mode = 0, m_kind = 0, m_page = 0, m_off = 0, m_cnt = 0;
   int m_flag = 1, m_err = 0;
   int m_data [P];
   bit m_val [P];
   int got_q [$];

   always @(posedge clk) begin
      if (!rst_n || session_end) begin
         m_mode = 0; m_cnt = 0; m_flag = 1; m_err = 0;
         for (int i = 0; i < P; i++) m_val[i] = 1'b0;
      end else begin
         case (m_mode)
            0: if (cmd_start) begin
                  m_mode = 1; m_kind = cmd_kind;
                  m_page = cmd_addr / P; m_off = cmd_addr % P;
                  if ((cmd_kind & 1) == 0) m_flag = 0;
               end
            1: begin
                  if (data_valid) begin
                     if (m_val[m_off]) m_err = 1;
                     m_val[m_off] = 1'b1; m_data[m_off] = data_byte;
                     m_off = (m_off + 1) % P;
                  end
                  if (cmd_end) begin
                     m_cnt = 0;
                     if ((m_kind & 1) == 0) m_mode = 0;
                     else if ((m_kind & 2) != 0) m_mode = 2;
                     else m_mode = 3;
                  end
               end
            2: m_mode = 3;
            default: if (m_cnt == P - 1) begin
                  m_mode = 0; m_flag = 1;
                  for (int i = 0; i < P; i++) m_val[i] = 1'b0;
               end else m_cnt++;
         endcase
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R5 busy", int'(busy), int'(m_mode >= 2));
         check("R4 load_flag", int'(load_flag), m_flag);
         check("R9 reload_err", int'(reload_err), m_err);
         check("R5 erase strobe", int'(mem_erase), int'(m_mode == 2));
         check("R5 write strobe", int'(mem_wr_en), int'(m_mode == 3 && m_val[m_cnt]));
         if (m_mode == 2) check("R2 erase addr", int'(mem_addr), m_page * P);
         if (m_mode == 3 && m_val[m_cnt]) begin
            check("R2 write addr", int'(mem_addr), m_page * P + m_cnt);
            check("R3 write data", int'(mem_wr_data), m_data[m_cnt]);
         end
         if (mem_wr_en) got_q.push_back(32'h0100_0000 | (int'(mem_addr) << 8) | int'(mem_wr_data));
         if (mem_erase) got_q.push_back(32'h0200_0000 | (int'(mem_addr) << 8));
      end
   end

   function automatic int wr(int a, int d); return 32'h0100_0000 | (a << 8) | d; endfunction
   function automatic int er(int a); return 32'h0200_0000 | (a << 8); endfunction

   task automatic check_q(string req, int exp [$]);
      check({req, " access count"}, got_q.size(), exp.size());
      for (int i = 0; i < exp.size() && i < got_q.size(); i++)
         check({req, " access"}, got_q[i], exp[i]);
      got_q.delete();
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   task automatic run_cmd(int kind, int addr, int bytes [$]);
      @(negedge clk);
      cmd_start = 1'b1; cmd_kind = 2'(kind); cmd_addr = 16'(addr);
      @(negedge clk);
      cmd_start = 1'b0;
      foreach (bytes[i]) begin
         data_valid = 1'b1; data_byte = 8'(bytes[i]);
         @(negedge clk);
      end
      data_valid = 1'b0;
      cmd_end = 1'b1;
      @(negedge clk);
      cmd_end = 1'b0;
      wait_idle();
   endtask

   task automatic pulse_session_end();
      @(negedge clk); session_end = 1'b1;
      @(negedge clk); session_end = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1; checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy", int'(busy), 0);
      check("R1 load_flag", int'(load_flag), 1);
      check("R1 reload_err", int'(reload_err), 0);
      check("R1 strobes", int'(mem_wr_en | mem_erase), 0);
      rst_n = 1'b1;

      // R4 R8 R7: load three bytes, then a zero-byte commit on another offset
      run_cmd(0, 'h1234, '{'hA1, 'hB2, 'hC3});
      check("R4 flag low after load", int'(load_flag), 0);
      check_q("R4 load writes nothing", '{});
      run_cmd(1, 'h1200, '{});
      check_q("R7 zero-byte commit", '{wr('h1234,'hA1), wr('h1235,'hB2), wr('h1236,'hC3)});
      check("R6 flag high after commit", int'(load_flag), 1);
      run_cmd(1, 'h1200, '{});
      check_q("R6 markers cleared", '{});

      // R3: wrap inside the page
      run_cmd(1, 'h207E, '{'h5A, 'h6B, 'h7C, 'h8D});
      check_q("R3 wrap", '{wr('h2040,'h7C), wr('h2041,'h8D), wr('h207E,'h5A), wr('h207F,'h6B)});

      // R8 R5: scattered loads, erase then commit
      run_cmd(0, 'h0005, '{'h11});
      run_cmd(0, 'h0010, '{'h22});
      run_cmd(3, 'h0000, '{});
      check_q("R8 scattered with erase", '{er('h0000), wr('h0005,'h11), wr('h0010,'h22)});

      // R7: erase only
      run_cmd(3, 'h4444, '{});
      check_q("R7 erase only", '{er('h4440)});

      // R4: kind 2'b10 behaves as a load
      run_cmd(2, 'h0600, '{'hF0});
      check("R4 kind10 no busy flag", int'(load_flag), 0);
      check_q("R4 kind10 writes nothing", '{});
      run_cmd(1, 'h0600, '{});
      check_q("R4 kind10 data kept", '{wr('h0600,'hF0)});

      // R9: overwrite of a loaded byte
      run_cmd(0, 'h0100, '{'h44, 'h55});
      check("R9 no error yet", int'(reload_err), 0);
      run_cmd(0, 'h0100, '{'h66});
      check("R9 error set", int'(reload_err), 1);
      run_cmd(1, 'h0100, '{});
      check_q("R9 newer byte wins", '{wr('h0100,'h66), wr('h0101,'h55)});
      check("R9 error sticky", int'(reload_err), 1);
      pulse_session_end();
      check("R10 error cleared", int'(reload_err), 0);

      // R11: stimulus during busy is ignored
      run_cmd(0, 'h0300, '{'h77});
      @(negedge clk); cmd_start = 1'b1; cmd_kind = 2'b01; cmd_addr = 16'h0300;
      @(negedge clk); cmd_start = 1'b0; cmd_end = 1'b1;
      @(negedge clk); cmd_end = 1'b0;
      cmd_start = 1'b1; cmd_kind = 2'b00; cmd_addr = 16'h0333;
      data_valid = 1'b1; data_byte = 8'h99;
      repeat (5) @(negedge clk);
      cmd_end = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0; data_valid = 1'b0; cmd_end = 1'b0;
      wait_idle();
      check("R11 load ignored while busy", int'(load_flag), 1);
      check_q("R11 only buffered byte", '{wr('h0300,'h77)});
      @(negedge clk); data_valid = 1'b1; data_byte = 8'hEE;
      @(negedge clk); data_valid = 1'b0;
      run_cmd(1, 'h0300, '{});
      check_q("R11 stray data ignored", '{});

      // R10: session end discards loads and aborts a sweep
      run_cmd(0, 'h0400, '{'h12, 'h34});
      pulse_session_end();
      check("R10 flag set", int'(load_flag), 1);
      run_cmd(1, 'h0400, '{});
      check_q("R10 buffer discarded", '{});
      run_cmd(0, 'h0520, '{'hAB});
      @(negedge clk); cmd_start = 1'b1; cmd_kind = 2'b01; cmd_addr = 16'h0500;
      @(negedge clk); cmd_start = 1'b0; cmd_end = 1'b1;
      @(negedge clk); cmd_end = 1'b0;
      repeat (5) @(negedge clk);
      session_end = 1'b1;
      @(negedge clk); session_end = 1'b0;
      check("R10 sweep aborted", int'(busy), 0);
      run_cmd(1, 'h0500, '{});
      check_q("R10 aborted commit wrote nothing", '{});

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule